// File: doc/BRIEF.md
# SECDED 16-to-22 Codec

This block guards a 16-bit data word with a 22-bit code that corrects any single flipped bit and detects any two flipped bits. It holds an encoder and a decoder side by side, each with its own ports, so a transmit path and a receive path can share one instance. The code word is a 21-bit Hamming word, with five check bits at the power-of-two positions, plus an overall parity bit at the top.

The decoder works out a 5-bit syndrome and the parity of all 22 received bits. From these it decides whether the word is clean, whether one bit is to be repaired, or whether the word cannot be repaired. A syndrome that points past the last Hamming position is never used to flip a bit. Both sides are combinational. A parameter adds one register stage on all outputs, and this stage is on by default.

Top module: `secded_codec`

## Requirements
- R1: In the encoder output, code bit index i (0-based) holds Hamming position i+1 for i = 0..20. Check bits sit at indices 0, 1, 3, 7 and 15. Data bits fill the other indices in ascending order, so data bit 0 is at index 2 and data bit 15 is at index 20. Check bit k is the XOR of all data bits whose Hamming position has bit k set.
- R2: Code bit 21 of the encoder output makes the XOR of all 22 code bits equal to zero.
- R3: When the decoder gets a valid code word, it returns the encoded data with both flags low.
- R4: When exactly one of code bits 0..20 is flipped, the decoder returns the original data, raises the corrected flag and keeps the uncorrectable flag low.
- R5: When only code bit 21 is flipped, the decoder returns the data unchanged, with the corrected flag high and the uncorrectable flag low.
- R6: When any two distinct code bits are flipped, the decoder raises the uncorrectable flag, keeps the corrected flag low and drives all-zero data.
- R7: When overall parity is odd and the syndrome value is in 22..31, the decoder raises the uncorrectable flag, keeps the corrected flag low and drives all-zero data.
- R8: The corrected and uncorrectable flags are never high at the same time.
- R9: With OUT_REG = 1, every output shows the result for the inputs sampled at the previous rising clock edge. While rst_n is low at a rising edge, every output becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_data_i | input | 16 | Data word to be encoded |
| enc_code_o | output | 22 | Encoded word |
| dec_code_i | input | 22 | Received word to be decoded |
| dec_data_o | output | 16 | Corrected data, zero when uncorrectable |
| dec_corr_o | output | 1 | A single error was corrected |
| dec_uncorr_o | output | 1 | The error cannot be corrected |

## Verification
With the default output stage, both the encoded word and the decoder results show up one rising edge after the inputs are applied, and they stay there until the next rising edge. The bench changes inputs on a falling edge, lets exactly one rising edge pass, and samples on the falling edge that follows. So every comparison sees the result of the word just applied. In one step, the bench probes right after changing the inputs and expects the old encoder output still to be present, which shows the one-cycle latency.

// File: rtl/secded_pkg.sv
// Package: shared widths, types and constant helpers for the 16-to-22 SECDED codec.
// Assumes a Hamming word indexed 1..HAM_W, with checks at power-of-two positions.
package secded_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned CHK_W  = 5;
    localparam int unsigned HAM_W  = DATA_W + CHK_W;
    localparam int unsigned CODE_W = HAM_W + 1;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [HAM_W:1]    ham_t;
    typedef logic [CHK_W-1:0]  syn_t;

    typedef enum logic [1:0] {
        ST_CLEAN   = 2'd0,
        ST_FIX_PAR = 2'd1,
        ST_FIX_BIT = 2'd2,
        ST_BAD     = 2'd3
    } dec_state_e;

    // True when p is a nonzero power of two (a check position).
    function automatic bit is_pow2(int unsigned p);
        return (p != 0) && ((p & (p - 1)) == 0);
    endfunction

    // Index of the data bit held at Hamming position p (p must not be a power of two).
    function automatic int unsigned data_idx(int unsigned p);
        int unsigned cnt;
        cnt = 0;
        for (int unsigned q = 1; q < p; q++) begin
            if (!is_pow2(q)) cnt++;
        end
        return cnt;
    endfunction

    // Mask of the Hamming positions covered by check bit k.
    function automatic ham_t cover_mask(int unsigned k);
        ham_t m;
        for (int unsigned p = 1; p <= HAM_W; p++) begin
            m[p] = ((p >> k) & 1) != 0;
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_enc.sv
// Module: secded_enc
// Places 16 data bits into a 21-bit Hamming word, fills the five checks and appends
// the overall parity bit. Purely combinational; no clock.
module secded_enc
    import secded_pkg::*;
(
    input  data_t data_i,
    output code_t code_o
);

    ham_t ham_data;
    ham_t ham_full;
    syn_t chk_bits;

    // Spread the data over the non-check positions; check positions start at zero.
    for (genvar p = 1; p <= HAM_W; p++) begin : g_place
        if (is_pow2(p)) begin : g_chk
            assign ham_data[p] = 1'b0;
            assign ham_full[p] = chk_bits[$clog2(p)];
        end else begin : g_dat
            assign ham_data[p] = data_i[data_idx(p)];
            assign ham_full[p] = data_i[data_idx(p)];
        end
    end

    // Each check bit is the parity of the data bits in its coverage group.
    for (genvar k = 0; k < CHK_W; k++) begin : g_chk_calc
        assign chk_bits[k] = ^(ham_data & cover_mask(k));
    end

    // Overall parity sits above the Hamming word so the full word XORs to zero.
    assign code_o = {^ham_full, ham_full};

endmodule

// File: rtl/secded_dec.sv
// Module: secded_dec
// Computes the syndrome and overall parity of a 22-bit word, repairs a single bit error,
// and flags words that cannot be repaired (double errors, out-of-range syndromes).
// Purely combinational.
module secded_dec
    import secded_pkg::*;
(
    input  code_t code_i,
    output data_t data_o,
    output logic  corr_o,
    output logic  uncorr_o
);

    ham_t       ham_rx;
    ham_t       flip_mask;
    ham_t       ham_fix;
    syn_t       syn;
    logic       par_bad;
    logic       syn_in_range;
    data_t      data_raw;
    dec_state_e state;

    assign ham_rx  = code_i[HAM_W-1:0];
    assign par_bad = ^code_i;

    // Syndrome bit k rechecks the coverage group of check k.
    for (genvar k = 0; k < CHK_W; k++) begin : g_syn
        assign syn[k] = ^(ham_rx & cover_mask(k));
    end

    // One-hot decode of the syndrome onto Hamming positions.
    for (genvar p = 1; p <= HAM_W; p++) begin : g_flip
        assign flip_mask[p] = (syn == syn_t'(p));
    end

    assign syn_in_range = (syn <= syn_t'(HAM_W));

    // Classify the received word from syndrome and overall parity.
    always_comb begin
        if (syn == '0) begin
            state = par_bad ? ST_FIX_PAR : ST_CLEAN;
        end else if (par_bad && syn_in_range) begin
            state = ST_FIX_BIT;
        end else begin
            state = ST_BAD;
        end
    end

    // Flip the named bit only when a single in-range error was found.
    assign ham_fix = ham_rx ^ ((state == ST_FIX_BIT) ? flip_mask : '0);

    // Gather the data bits back from their Hamming positions.
    for (genvar p = 1; p <= HAM_W; p++) begin : g_pick
        if (!is_pow2(p)) begin : g_dat
            assign data_raw[data_idx(p)] = ham_fix[p];
        end
    end

    assign data_o   = (state == ST_BAD) ? '0 : data_raw;
    assign corr_o   = (state == ST_FIX_PAR) || (state == ST_FIX_BIT);
    assign uncorr_o = (state == ST_BAD);

endmodule

// File: rtl/secded_pipe.sv
// Module: secded_pipe
// Optional output stage: a register with synchronous active-low reset when REG_EN is set,
// a plain wire otherwise.
module secded_pipe #(
    parameter int unsigned WIDTH  = 8,
    parameter bit          REG_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    if (REG_EN) begin : g_reg
        // Capture the result each cycle; reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) q_o <= '0;
            else        q_o <= d_i;
        end
    end else begin : g_wire
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst_n;
        assign q_o = d_i;
    end

endmodule

// File: rtl/secded_codec.sv
// Module: secded_codec
// Top level: an independent encoder and decoder, each followed by the optional
// output stage chosen by OUT_REG. Assumes inputs are stable around the clock edge.
module secded_codec
    import secded_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_corr_o,
    output logic              dec_uncorr_o
);

    localparam int unsigned DEC_OUT_W = DATA_W + 2;

    code_t enc_code_c;
    data_t dec_data_c;
    logic  dec_corr_c;
    logic  dec_uncorr_c;

    secded_enc u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_c)
    );

    secded_dec u_dec (
        .code_i   (dec_code_i),
        .data_o   (dec_data_c),
        .corr_o   (dec_corr_c),
        .uncorr_o (dec_uncorr_c)
    );

    secded_pipe #(.WIDTH(CODE_W), .REG_EN(OUT_REG)) u_enc_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (enc_code_c),
        .q_o   (enc_code_o)
    );

    secded_pipe #(.WIDTH(DEC_OUT_W), .REG_EN(OUT_REG)) u_dec_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({dec_uncorr_c, dec_corr_c, dec_data_c}),
        .q_o   ({dec_uncorr_o, dec_corr_o, dec_data_o})
    );

endmodule

// File: rtl/secded_codec_chk.sv
// Module: secded_codec_chk
// Assertion checker for secded_codec, attached with bind. LAT mirrors the output stage.
// Inputs are delayed by LAT cycles so each property relates outputs to their own inputs.
module secded_codec_chk #(
    parameter bit LAT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] enc_data_i,
    input logic [21:0] enc_code_o,
    input logic [21:0] dec_code_i,
    input logic [15:0] dec_data_o,
    input logic        dec_corr_o,
    input logic        dec_uncorr_o
);

    logic        warm_q;
    logic [15:0] enc_ref;
    logic [21:0] dec_ref;

    // Marks the first full cycle after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    if (LAT) begin : g_lat
        // Hold the inputs that the registered outputs belong to.
        always_ff @(posedge clk) begin
            enc_ref <= enc_data_i;
            dec_ref <= dec_code_i;
        end
    end else begin : g_nolat
        assign enc_ref = enc_data_i;
        assign dec_ref = dec_code_i;
    end

    p_data0_pos_r1: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        enc_code_o[2] == enc_ref[0]);
    p_data15_pos_r1: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        enc_code_o[20] == enc_ref[15]);
    p_parity_even_r2: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        (^enc_code_o) == 1'b0);
    p_odd_flagged_r4: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        (^dec_ref) |-> (dec_corr_o || dec_uncorr_o));
    p_even_no_corr_r6: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        !(^dec_ref) |-> !dec_corr_o);
    p_uncorr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        dec_uncorr_o |-> (dec_data_o == 16'h0000));
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_corr_o && dec_uncorr_o));

endmodule

bind secded_codec secded_codec_chk #(.LAT(OUT_REG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enc_data_i   (enc_data_i),
    .enc_code_o   (enc_code_o),
    .dec_code_i   (dec_code_i),
    .dec_data_o   (dec_data_o),
    .dec_corr_o   (dec_corr_o),
    .dec_uncorr_o (dec_uncorr_o)
);

// File: tb/secded_codec_tb_top.sv
`timescale 1ns/1ps
module secded_codec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] enc_data_i = 16'hFFFF;
    logic [21:0] enc_code_o;
    logic [21:0] dec_code_i = 22'h3FFFFF;
    logic [15:0] dec_data_o;
    logic        dec_corr_o;
    logic        dec_uncorr_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    secded_codec dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_data_i   (enc_data_i),
        .enc_code_o   (enc_code_o),
        .dec_code_i   (dec_code_i),
        .dec_data_o   (dec_data_o),
        .dec_corr_o   (dec_corr_o),
        .dec_uncorr_o (dec_uncorr_o)
    );

    // Reference encoder written from R1/R2.
    function automatic logic [21:0] ref_encode(logic [15:0] d);
        logic [21:0] c;
        int di;
        c  = '0;
        di = 0;
        for (int p = 1; p <= 21; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p-1] = d[di];
                di++;
            end
        end
        for (int k = 0; k < 5; k++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= 21; p++) begin
                if (((p >> k) & 1) != 0 && (p & (p - 1)) != 0) par ^= c[p-1];
            end
            c[(1 << k) - 1] = par;
        end
        c[21] = ^c[20:0];
        return c;
    endfunction

    // Drive on the falling edge, let one rising edge pass, sample on the next falling edge.
    task automatic apply(input logic [15:0] d, input logic [21:0] c);
        enc_data_i = d;
        dec_code_i = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_enc(input string req, input logic [21:0] exp);
        checks++;
        if (enc_code_o !== exp) begin
            errors++;
            $display("FAIL %s enc_code_o actual=%h expected=%h", req, enc_code_o, exp);
        end
    endtask

    task automatic check_dec(input string req, input logic [15:0] ed, input logic ec, input logic eu);
        checks++;
        if (dec_data_o !== ed || dec_corr_o !== ec || dec_uncorr_o !== eu) begin
            errors++;
            $display("FAIL %s dec actual=%h/%b/%b expected=%h/%b/%b",
                     req, dec_data_o, dec_corr_o, dec_uncorr_o, ed, ec, eu);
        end
        checks++;
        if (dec_corr_o === 1'b1 && dec_uncorr_o === 1'b1) begin   // R8
            errors++;
            $display("FAIL R8 both flags actual=11 expected=not 11");
        end
    endtask

    initial begin : watchdog
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] d;
        logic [21:0] c;
        logic [21:0] prev;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset clears outputs despite nonzero inputs
        check_enc("R9 reset", 22'h0);
        check_dec("R9 reset", 16'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1 directed words
        apply(16'h0000, ref_encode(16'h0000));
        check_enc("R1 zero", 22'h0);
        apply(16'h0001, ref_encode(16'h0001));
        check_enc("R1 data0 index2", 22'h000007 | 22'h200000 | 22'h000000); // d0 at 2, checks 0,1; parity 1
        apply(16'hFFFF, ref_encode(16'hFFFF));
        check_enc("R1 all ones", ref_encode(16'hFFFF));

        // R9 latency: right after a new input, output still shows old result
        prev = enc_code_o;
        enc_data_i = 16'hA5A5;
        #1;
        check_enc("R9 latency hold", prev);
        @(posedge clk);
        @(negedge clk);
        check_enc("R9 latency update", ref_encode(16'hA5A5));

        // R7: syndrome 22 via flips at positions 16,4,2 (indices 15,3,1), odd parity
        c = ref_encode(16'h1234) ^ ((22'd1 << 15) | (22'd1 << 3) | (22'd1 << 1));
        apply(16'h1234, c);
        check_dec("R7 syndrome 22", 16'h0, 1'b0, 1'b1);
        // R7: syndrome 31 via positions 16,8,4,2,1 (indices 15,7,3,1,0)
        c = ref_encode(16'h00FF) ^ ((22'd1 << 15) | (22'd1 << 7) | (22'd1 << 3) | (22'd1 << 1) | 22'd1);
        apply(16'h00FF, c);
        check_dec("R7 syndrome 31", 16'h0, 1'b0, 1'b1);

        for (int n = 0; n < 40; n++) begin
            d = 16'($urandom);
            c = ref_encode(d);
            apply(d, c);
            check_enc("R1 R2 random", c);
            check_dec("R3 clean", d, 1'b0, 1'b0);
            for (int i = 0; i < 22; i++) begin
                apply(d, c ^ (22'd1 << i));
                if (i < 21) check_dec("R4 single flip", d, 1'b1, 1'b0);
                else        check_dec("R5 parity bit flip", d, 1'b1, 1'b0);
            end
            for (int t = 0; t < 4; t++) begin
                int i;
                int j;
                i = int'($urandom % 22);
                j = (i + 1 + int'($urandom % 21)) % 22;
                apply(d, c ^ (22'd1 << i) ^ (22'd1 << j));
                check_dec("R6 double flip", 16'h0, 1'b0, 1'b1);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule